// File: doc/BRIEF.md
# Packed Dual-MAC Dot Product Engine

This engine computes the dot product of two vectors of signed 16-bit elements that sit in two separate memories, one for coefficients and one for data. Each 32-bit memory word carries two neighbouring elements. On every cycle of its loop the engine fetches one word from each memory and multiplies the two low halves and the two high halves in a pair of parallel multipliers. The low-half products build up an even partial sum and the high-half products build up an odd partial sum. The two partial sums are added only once, after the last product has been taken in, and the result is written to a result port as one halfword.

A job starts with a one-cycle start pulse. The pulse carries the two word base addresses, the result address and the element count N, which must be even. The read ports are synchronous: data comes back a fixed number of cycles after the address is issued. The engine issues one address pair per cycle, waits for the read and multiply pipeline to empty, merges the sums, writes the result, and then raises done for one cycle.

The controller has six states. IDLE waits for start. ISSUE sends one read per cycle while the pair counter is above zero. DRAIN waits until no read or product is in flight. MERGE adds the partial sums. WRITE drives the result write. DONE raises done. The transitions are: IDLE to ISSUE on start with N/2 > 0, IDLE to DRAIN on start with N = 0, ISSUE to ISSUE while more than one pair is left, ISSUE to DRAIN on the last pair, DRAIN to MERGE once the pipeline is empty, MERGE to WRITE, WRITE to DONE, and DONE to IDLE.

Top module: `pdot_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, both read enables and res_wr_en_o are low.
- R2: In every 32-bit word, bits 15:0 hold element n and bits 31:16 hold element n+1. The same layout applies to the coefficient memory and the data memory.
- R3: Each product is a signed 16x16 multiply. The low-half product goes to the even sum and the high-half product goes to the odd sum. Low halves are paired only with low halves, and high halves only with high halves.
- R4: The written halfword is bits 15:0 of the 32-bit wrap-around sum (even sum plus odd sum). No saturation is applied. It is written to res_addr_i as captured at start.
- R5: A job issues exactly N/2 reads on each port, in consecutive cycles. Both ports read in the same cycle. The addresses are base, base+1, and so on. Bit 0 of len_i is ignored.
- R6: Read data is used four cycles after its address is issued. Products are ready one cycle after that. Counting the start cycle as cycle 0, the first read is in cycle 1 and the result write is in cycle N/2+8. When N = 0 the write is in cycle 3.
- R7: Both partial sums are cleared at start, so a job's result does not depend on earlier jobs.
- R8: A start pulse while busy_o is high is ignored. The running job keeps its addresses and result, and no second write follows.
- R9: done_o is high for exactly one cycle, the cycle after the result write. busy_o is high from the cycle after start through the done cycle.
- R10: With N = 0 the engine issues no reads and writes the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle job start |
| len_i | input | LEN_W | Element count N (even) |
| coef_base_i | input | AW | Word address of the first coefficient pair |
| data_base_i | input | AW | Word address of the first data pair |
| res_addr_i | input | AW | Address for the result halfword |
| coef_rd_en_o | output | 1 | Coefficient read request |
| coef_rd_addr_o | output | AW | Coefficient read address |
| coef_rd_data_i | input | 32 | Coefficient word, valid four cycles after request |
| data_rd_en_o | output | 1 | Data read request |
| data_rd_addr_o | output | AW | Data read address |
| data_rd_data_i | input | 32 | Data word, valid four cycles after request |
| res_wr_en_o | output | 1 | Result write strobe |
| res_wr_addr_o | output | AW | Result write address |
| res_wr_data_o | output | 16 | Result halfword |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while reads are still in flight. The engine must ignore it and must neither clear the partial sums nor move the pointers. The bench raises start with different lengths and bases a few cycles into a running job. It then checks that the write address, the result and the read sequence all belong to the first job, and that no second write ever follows. Random lengths and word contents are mixed with cases that make the sum wrap past 16 bits, a zero-length job, and half-populated words that would expose a swap between the lanes.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int LANES  = WORD_W / HALF_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_MERGE,
        ST_WRITE,
        ST_DONE
    } pdot_state_e;
endpackage

// File: rtl/pdot_ctrl.sv
module pdot_ctrl
    import pdot_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LEN_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [AW-1:0] coef_base_i,
    input  logic [AW-1:0] data_base_i,
    input  logic [AW-1:0] res_addr_i,
    input  logic          pipe_busy_i,
    output logic          issue_o,
    output logic [AW-1:0] coef_addr_o,
    output logic [AW-1:0] data_addr_o,
    output logic          acc_clr_o,
    output logic          merge_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          done_o,
    output logic          busy_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    pdot_state_e state_q, state_d;
    logic [LEN_W-1:0] pairs_left_q;
    logic [LEN_W-1:0] pairs_req;
    logic [AW-1:0]    cptr_q, dptr_q, raddr_q;

    assign pairs_req = len_i >> 1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (pairs_req == '0) ? ST_DRAIN : ST_ISSUE;
            ST_ISSUE: if (pairs_left_q == ONE) state_d = ST_DRAIN;
            ST_DRAIN: if (!pipe_busy_i) state_d = ST_MERGE;
            ST_MERGE: state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue_o   = 1'b0;
        acc_clr_o = 1'b0;
        merge_o   = 1'b0;
        wr_en_o   = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                acc_clr_o = start_i;
            end
            ST_ISSUE: issue_o = 1'b1;
            ST_DRAIN: ;
            ST_MERGE: merge_o = 1'b1;
            ST_WRITE: wr_en_o = 1'b1;
            ST_DONE:  done_o  = 1'b1;
            default:  busy_o  = 1'b0;
        endcase
    end

    // job registers: pair counter and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pairs_left_q <= '0;
            cptr_q       <= '0;
            dptr_q       <= '0;
            raddr_q      <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            pairs_left_q <= pairs_req;
            cptr_q       <= coef_base_i;
            dptr_q       <= data_base_i;
            raddr_q      <= res_addr_i;
        end else if (state_q == ST_ISSUE) begin
            pairs_left_q <= pairs_left_q - ONE;
            cptr_q       <= cptr_q + AW'(1);
            dptr_q       <= dptr_q + AW'(1);
        end
    end

    assign coef_addr_o = cptr_q;
    assign data_addr_o = dptr_q;
    assign wr_addr_o   = raddr_q;
endmodule

// File: rtl/pdot_rd_track.sv
module pdot_rd_track #(
    parameter int RD_LAT  = 4,
    parameter int MUL_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    output logic acc_en_o,
    output logic busy_o
);
    localparam int DEPTH = RD_LAT + MUL_LAT;

    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[DEPTH-2:0], issue_i};
    end

    assign acc_en_o = vld_q[DEPTH-1];
    assign busy_o   = |vld_q;
endmodule

// File: rtl/pdot_mac_lane.sv
module pdot_mac_lane
    import pdot_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int MUL_LAT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [HALF_W-1:0]       coef_i,
    input  logic [HALF_W-1:0]       data_i,
    input  logic                    acc_clr_i,
    input  logic                    acc_en_i,
    output logic signed [ACC_W-1:0] acc_o
);
    logic signed [HALF_W-1:0] a_s, x_s;
    logic signed [PROD_W-1:0] prod_d;
    logic signed [PROD_W-1:0] stg_q [MUL_LAT];
    logic signed [ACC_W-1:0]  acc_q;

    assign a_s    = $signed(coef_i);
    assign x_s    = $signed(data_i);
    assign prod_d = a_s * x_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= prod_d;
    end

    for (genvar s = 1; s < MUL_LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         acc_q <= '0;
        else if (acc_clr_i) acc_q <= '0;
        else if (acc_en_i)  acc_q <= acc_q + ACC_W'(stg_q[MUL_LAT-1]);
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/pdot_engine.sv
module pdot_engine
    import pdot_pkg::*;
#(
    parameter int AW      = 10,
    parameter int LEN_W   = 10,
    parameter int RD_LAT  = 4,
    parameter int MUL_LAT = 1,
    parameter int ACC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [AW-1:0]     coef_base_i,
    input  logic [AW-1:0]     data_base_i,
    input  logic [AW-1:0]     res_addr_i,
    output logic              coef_rd_en_o,
    output logic [AW-1:0]     coef_rd_addr_o,
    input  logic [31:0]       coef_rd_data_i,
    output logic              data_rd_en_o,
    output logic [AW-1:0]     data_rd_addr_o,
    input  logic [31:0]       data_rd_data_i,
    output logic              res_wr_en_o,
    output logic [AW-1:0]     res_wr_addr_o,
    output logic [15:0]       res_wr_data_o,
    output logic              busy_o,
    output logic              done_o
);
    logic issue, acc_clr, merge, pipe_busy, acc_en;
    logic signed [ACC_W-1:0] lane_acc [LANES];
    logic [HALF_W-1:0] res_q;

    pdot_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .coef_base_i (coef_base_i),
        .data_base_i (data_base_i),
        .res_addr_i  (res_addr_i),
        .pipe_busy_i (pipe_busy),
        .issue_o     (issue),
        .coef_addr_o (coef_rd_addr_o),
        .data_addr_o (data_rd_addr_o),
        .acc_clr_o   (acc_clr),
        .merge_o     (merge),
        .wr_en_o     (res_wr_en_o),
        .wr_addr_o   (res_wr_addr_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    pdot_rd_track #(.RD_LAT(RD_LAT), .MUL_LAT(MUL_LAT)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue),
        .acc_en_o (acc_en),
        .busy_o   (pipe_busy)
    );

    // lane 0 = low halves (even sum), lane 1 = high halves (odd sum)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pdot_mac_lane #(.ACC_W(ACC_W), .MUL_LAT(MUL_LAT)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .coef_i    (coef_rd_data_i[g*HALF_W +: HALF_W]),
            .data_i    (data_rd_data_i[g*HALF_W +: HALF_W]),
            .acc_clr_i (acc_clr),
            .acc_en_i  (acc_en),
            .acc_o     (lane_acc[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res_q <= '0;
        else if (merge) res_q <= HALF_W'(lane_acc[0] + lane_acc[1]);
    end

    assign coef_rd_en_o  = issue;
    assign data_rd_en_o  = issue;
    assign res_wr_data_o = res_q;
endmodule

// File: rtl/pdot_engine_chk.sv
module pdot_engine_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          coef_rd_en_o,
    input logic [AW-1:0] coef_rd_addr_o,
    input logic          data_rd_en_o,
    input logic [AW-1:0] data_rd_addr_o,
    input logic          res_wr_en_o,
    input logic          busy_o,
    input logic          done_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!coef_rd_en_o && !res_wr_en_o && !done_o));

    p_ports_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_en_o |-> data_rd_en_o);

    p_ports_paired_rev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_en_o |-> coef_rd_en_o);

    p_coef_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_rd_en_o && $past(coef_rd_en_o)) |-> coef_rd_addr_o == $past(coef_rd_addr_o) + AW'(1));

    p_data_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_en_o && $past(data_rd_en_o)) |-> data_rd_addr_o == $past(data_rd_addr_o) + AW'(1));

    p_no_read_at_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en_o |-> !coef_rd_en_o);

    p_done_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en_o |=> done_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_start_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> busy_o);
endmodule

bind pdot_engine pdot_engine_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .coef_rd_en_o   (coef_rd_en_o),
    .coef_rd_addr_o (coef_rd_addr_o),
    .data_rd_en_o   (data_rd_en_o),
    .data_rd_addr_o (data_rd_addr_o),
    .res_wr_en_o    (res_wr_en_o),
    .busy_o         (busy_o),
    .done_o         (done_o)
);

// File: tb/pdot_engine_bench.sv
`timescale 1ns/1ps
module pdot_engine_bench;
    localparam int AW     = 10;
    localparam int LEN_W  = 10;
    localparam int RD_LAT = 4;
    localparam int MSZ    = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic [AW-1:0] cbase = '0, dbase = '0, raddr = '0;
    logic c_en, d_en, w_en, busy, done;
    logic [AW-1:0] c_addr, d_addr, w_addr;
    logic [31:0] c_data, d_data;
    logic [15:0] w_data;

    logic [31:0] cmem [MSZ];
    logic [31:0] dmem [MSZ];
    logic [AW-1:0] cpipe [RD_LAT];
    logic [AW-1:0] dpipe [RD_LAT];

    int tot = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pdot_engine u_pdot_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len),
        .coef_base_i(cbase), .data_base_i(dbase), .res_addr_i(raddr),
        .coef_rd_en_o(c_en), .coef_rd_addr_o(c_addr), .coef_rd_data_i(c_data),
        .data_rd_en_o(d_en), .data_rd_addr_o(d_addr), .data_rd_data_i(d_data),
        .res_wr_en_o(w_en), .res_wr_addr_o(w_addr), .res_wr_data_o(w_data),
        .busy_o(busy), .done_o(done)
    );

    // memory model: word visible RD_LAT cycles after the address
    always_ff @(posedge clk) begin
        cpipe[0] <= c_addr;
        dpipe[0] <= d_addr;
        for (int i = 1; i < RD_LAT; i++) begin
            cpipe[i] <= cpipe[i-1];
            dpipe[i] <= dpipe[i-1];
        end
    end
    assign c_data = cmem[cpipe[RD_LAT-1]];
    assign d_data = dmem[dpipe[RD_LAT-1]];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] exp_dot(input int cb, input int db, input int pairs);
        int s = 0;
        for (int k = 0; k < pairs; k++) begin
            logic [31:0] cw, dw;
            cw = cmem[(cb + k) % MSZ];
            dw = dmem[(db + k) % MSZ];
            s += int'($signed(cw[15:0])) * int'($signed(dw[15:0]));
            s += int'($signed(cw[31:16])) * int'($signed(dw[31:16]));
        end
        return s[15:0];
    endfunction

    task automatic run_job(input int n, input int cb, input int db, input int ra,
                           input bit poke);
        int pairs = n / 2;
        int lat = 0;
        int rcnt = 0;
        int first = -1;
        int last = -1;
        int aerr = 0;
        logic [15:0] expv;
        expv = exp_dot(cb, db, pairs);
        @(negedge clk);
        start = 1'b1; len = LEN_W'(n);
        cbase = AW'(cb); dbase = AW'(db); raddr = AW'(ra);
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (poke && lat == 3) begin
                start = 1'b1; len = LEN_W'(40);
                cbase = AW'(cb + 7); dbase = AW'(db + 3); raddr = AW'(ra + 1);
            end
            if (poke && lat == 4) start = 1'b0;
            if (c_en || d_en) begin
                if (!(c_en && d_en) || c_addr != AW'(cb + rcnt) || d_addr != AW'(db + rcnt))
                    aerr++;
                if (first < 0) first = lat;
                last = lat;
                rcnt++;
            end
        end while (!w_en && lat < 3000);
        check(w_en == 1'b1, "R6", "write seen", int'(w_en), 1);
        check(w_data == expv, "R4", "result (R3 lanes)", int'(w_data), int'(expv));
        check(w_addr == AW'(ra), "R4", "write address", int'(w_addr), ra);
        check(lat == ((pairs == 0) ? 3 : pairs + 8), "R6", "write cycle", lat,
              (pairs == 0) ? 3 : pairs + 8);
        check(rcnt == pairs, "R5", "read count", rcnt, pairs);
        check(aerr == 0, "R5", "read address mismatches", aerr, 0);
        if (pairs > 0) begin
            check(first == 1, "R6", "first read cycle", first, 1);
            check(last - first + 1 == rcnt, "R5", "read burst span", last - first + 1, rcnt);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b1, "R9", "done after write", int'(done), 1);
        check(w_en == 1'b0, "R8", "single write", int'(w_en), 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", int'(done), 0);
        if (poke) begin
            int extra = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (w_en || c_en || busy) extra++;
            end
            check(extra == 0, "R8", "no activity from ignored start", extra, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tot++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0d07);
        for (int i = 0; i < MSZ; i++) begin
            cmem[i] = $urandom;
            dmem[i] = $urandom;
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !c_en && !d_en && !w_en, "R1", "idle after reset",
              int'({busy, done, c_en, d_en, w_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !c_en && !w_en, "R1", "idle after release",
              int'({busy, done, c_en, w_en}), 0);

        // R10: empty vector
        run_job(0, 100, 200, 5, 1'b0);
        check(w_data == 16'h0, "R10", "zero-length result", int'(w_data), 0);

        // R4: sum wraps, no saturation: 2*0x7fff^2 = 0x7ffe0002 -> 0x0002
        cmem[900] = 32'h7fff_7fff; dmem[900] = 32'h7fff_7fff;
        run_job(2, 900, 900, 17, 1'b0);
        check(w_data == 16'h0002, "R4", "wrap without saturation", int'(w_data), 2);

        // R2 R3: only low halves populated in data, only high in coef -> products all 0
        for (int k = 0; k < 8; k++) begin
            cmem[910 + k] = {16'(k + 3), 16'h0000};
            dmem[910 + k] = {16'h0000, 16'(k + 5)};
        end
        run_job(16, 910, 910, 33, 1'b0);
        check(w_data == 16'h0, "R3", "no cross-lane pairing", int'(w_data), 0);

        // R2: low-half element n, negative values in one lane only
        for (int k = 0; k < 4; k++) begin
            cmem[930 + k] = {16'h0000, 16'hffff};
            dmem[930 + k] = {16'h0001, 16'(k + 1)};
        end
        run_job(8, 930, 930, 41, 1'b0);
        check(w_data == 16'hfff6, "R2", "low-half lane sum -10", int'(w_data), 16'hfff6);

        // R8: start while busy
        run_job(20, 300, 400, 60, 1'b1);
        run_job(2, 10, 20, 61, 1'b1);

        // R7: back-to-back random jobs
        for (int j = 0; j < 24; j++) begin
            int n = 2 * int'($urandom_range(1, 40));
            run_job(n, int'($urandom_range(0, MSZ - 1)), int'($urandom_range(0, MSZ - 1)),
                    int'($urandom_range(0, MSZ - 1)), 1'b0);
        end
        // R5: odd length bit ignored, and a long run
        run_job(7, 500, 600, 3, 1'b0);
        run_job(300, 50, 700, 9, 1'b0);

        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end
endmodule